// File: doc/BRIEF.md
# Two-Channel Frame Slot Serializer/Deserializer

This block places two audio channels at programmable bit positions inside a serial frame and pulls two channels back out of a received frame. An external frame generator supplies a bit strobe, the index of the current bit within the frame, and a frame-start pulse. On each strobed bit the block drives one transmit bit and samples one receive bit. Each channel has its own window, described by an enable, a start index and a width code. Transmit and receive each have their own window settings. Both directions share one packing mode.

On the transmit side, samples come from a show-ahead FIFO word port. In unpacked mode each channel window consumes one 32-bit word. In packed mode a single word carries both 16-bit channels. On the receive side, captured bits are assembled into the same word format and pushed toward a receive FIFO. Data is sent and received MSB first. A sample sits in the upper bits of its word (or of its half-word when packed), and the unused low bits are zero. Configuration inputs are sampled only at frame start, so software can rewrite them at any time without corrupting a frame in flight.

Top module: `slot_codec`

## Requirements
- R1: A channel config half-word is {ext[15], en[14], pos[13:4], code[3:0]}. The channel width is 8 + code + 16*ext bits, clamped to at most 32. Channel 1 is bits 31:16 of a config word and channel 2 is bits 15:0.
- R2: When the strobed bit index equals an enabled transmit channel's pos, that bit carries the sample MSB. The following strobed bits carry the next lower bits, for width bits in total. tx_sd updates on the clock edge that ends a strobed cycle and holds between strobes.
- R3: tx_sd is 0 on every strobed bit outside an enabled transmit window. A disabled channel never requests a word.
- R4: In unpacked mode each enabled transmit window pops one word, with tx_pop high in the cycle of its first bit. Word bit 31 is sent first.
- R5: In packed mode, one word is popped at channel 1's window start. Channel 1 sends bits 15:0 of that word starting from bit 15, and channel 2 sends bits 31:16 starting from bit 31.
- R6: If no word is available when a window needs one, that window sends zeros and tx_err pulses in that cycle instead of tx_pop.
- R7: A received channel is returned in its word with its first bit at bit 31 and zeros below its width. rx_push is high for one cycle, on the edge after the strobe that carries the window's last bit.
- R8: In packed receive mode with both channels enabled, one word {ch2[31:16 half], ch1 half} is pushed after channel 2 completes. Each half is left-aligned within its 16 bits.
- R9: When rx_full is high at the completion of a word, the word is dropped and rx_err pulses in place of rx_push.
- R10: tx_cfg, rx_cfg and pack_mode take effect only in a cycle with frame_start. Changes made mid-frame have no effect until the next frame start.
- R11: After reset all windows are disabled and tx_sd, tx_pop, tx_err, rx_push and rx_err are 0.
- R12: The transmit and receive configurations are independent. Disabled receive windows push nothing, and disabled transmit windows pop nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Strobe: one frame bit in this cycle |
| bit_idx | input | 10 | Index of the current bit in the frame |
| frame_start | input | 1 | First bit of a frame; configuration is sampled here |
| pack_mode | input | 1 | Two 16-bit channels per word when 1 |
| tx_cfg | input | 32 | Transmit channel windows (ch1 upper, ch2 lower) |
| rx_cfg | input | 32 | Receive channel windows (ch1 upper, ch2 lower) |
| tx_word | input | 32 | Head word of the transmit FIFO |
| tx_valid | input | 1 | Transmit FIFO holds a word |
| tx_pop | output | 1 | Consume the head word (same cycle) |
| tx_err | output | 1 | Underrun: a window found no word |
| tx_sd | output | 1 | Serial transmit data |
| rx_sd | input | 1 | Serial receive data |
| rx_word | output | 32 | Assembled receive word |
| rx_push | output | 1 | rx_word is valid for the receive FIFO |
| rx_full | input | 1 | Receive FIFO cannot accept a word |
| rx_err | output | 1 | Overrun: a finished word was dropped |

## Verification
tx_pop and tx_err are combinational and are due in the same cycle as the strobe that opens a window. The bench reads them 1 ns after driving that strobe at the falling edge. tx_sd for bit i is registered and is read 1 ns after the rising edge that closes the strobe for bit i. rx_push and rx_err are read at the same point after the strobe carrying a window's last bit. Each strobed bit is followed by an idle cycle, so any output that moved without a strobe would show up as a misplaced bit or an extra push. Configuration changes are made in the middle of a frame to show that they take hold only at the next frame start.

// File: rtl/slot_codec_pkg.sv
package slot_codec_pkg;
    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;
    localparam int POS_W  = 10;
    localparam int CODE_W = 4;
    localparam int NCH    = 2;
    localparam int CNT_W  = $clog2(WORD_W + 1);
    localparam int BIT_W  = $clog2(WORD_W);
    localparam int BASE_W = 8;
    localparam int EXT_W  = 16;

    typedef struct packed {
        logic             ext;
        logic             en;
        logic [POS_W-1:0] pos;
        logic [CODE_W-1:0] code;
    } ch_cfg_t;

    // Width of a channel window in bits, clamped to one word.
    function automatic logic [CNT_W-1:0] ch_width(ch_cfg_t c);
        int w;
        w = BASE_W + int'(c.code) + (c.ext ? EXT_W : 0);
        if (w > WORD_W) w = WORD_W;
        return CNT_W'(w);
    endfunction

    // Channel 0 (first channel) lives in the upper half of a config word.
    function automatic ch_cfg_t pick_ch(logic [WORD_W-1:0] r, int ch);
        return ch_cfg_t'((ch == 0) ? r[WORD_W-1:HALF_W] : r[HALF_W-1:0]);
    endfunction
endpackage

// File: rtl/slot_tx.sv
module slot_tx
    import slot_codec_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bit_en,
    input  logic [POS_W-1:0]      bit_idx,
    input  logic                  pack_mode,
    input  ch_cfg_t [NCH-1:0]     cfg,
    input  logic [WORD_W-1:0]     tx_word,
    input  logic                  tx_valid,
    output logic                  tx_pop,
    output logic                  tx_err,
    output logic                  tx_sd
);
    typedef struct packed {
        logic [NCH-1:0][WORD_W-1:0] sh;
        logic [NCH-1:0][CNT_W-1:0]  rem;
        logic [HALF_W-1:0]          hold;
        logic                       sd;
    } tx_st_t;

    tx_st_t st_d, st_q;

    always_comb begin
        logic [WORD_W-1:0] load;
        logic [WORD_W-1:0] word_in;
        logic              need;
        logic [NCH-1:0]    out_b;
        logic [NCH-1:0]    act;
        st_d    = st_q;
        tx_pop  = 1'b0;
        tx_err  = 1'b0;
        load    = '0;
        word_in = '0;
        need    = 1'b0;
        out_b   = '0;
        act     = '0;
        if (bit_en) begin
            for (int c = 0; c < NCH; c++) begin
                if (cfg[c].en && (bit_idx == cfg[c].pos)) begin
                    need = (c == 0) || !pack_mode || !cfg[0].en;
                    if (need) begin
                        if (tx_valid) tx_pop = 1'b1;
                        else          tx_err = 1'b1;
                    end
                    word_in = (need && tx_valid) ? tx_word : '0;
                    if (!pack_mode) begin
                        load = word_in;
                    end else if (c == 0) begin
                        load = {word_in[HALF_W-1:0], {HALF_W{1'b0}}};
                        st_d.hold = word_in[WORD_W-1:HALF_W];
                    end else if (need) begin
                        load = {word_in[WORD_W-1:HALF_W], {HALF_W{1'b0}}};
                    end else begin
                        load = {st_q.hold, {HALF_W{1'b0}}};
                    end
                    out_b[c]    = load[WORD_W-1];
                    act[c]      = 1'b1;
                    st_d.sh[c]  = load << 1;
                    st_d.rem[c] = ch_width(cfg[c]) - CNT_W'(1);
                end else if (st_q.rem[c] != '0) begin
                    out_b[c]    = st_q.sh[c][WORD_W-1];
                    act[c]      = 1'b1;
                    st_d.sh[c]  = st_q.sh[c] << 1;
                    st_d.rem[c] = st_q.rem[c] - CNT_W'(1);
                end
            end
            st_d.sd = act[0] ? out_b[0] : out_b[1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_sd = st_q.sd;
endmodule

// File: rtl/slot_rx.sv
module slot_rx
    import slot_codec_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bit_en,
    input  logic [POS_W-1:0]      bit_idx,
    input  logic                  pack_mode,
    input  ch_cfg_t [NCH-1:0]     cfg,
    input  logic                  rx_sd,
    input  logic                  rx_full,
    output logic [WORD_W-1:0]     rx_word,
    output logic                  rx_push,
    output logic                  rx_err
);
    typedef struct packed {
        logic [NCH-1:0][WORD_W-1:0] acc;
        logic [NCH-1:0][CNT_W-1:0]  cnt;
        logic [HALF_W-1:0]          hold;
        logic [WORD_W-1:0]          word;
        logic                       push;
        logic                       err;
    } rx_st_t;

    rx_st_t st_d, st_q;

    always_comb begin
        logic [WORD_W-1:0] tmp;
        logic [WORD_W-1:0] wd;
        logic [HALF_W-1:0] half;
        logic [BIT_W-1:0]  bpos;
        logic              done;
        st_d      = st_q;
        st_d.push = 1'b0;
        st_d.err  = 1'b0;
        tmp  = '0;
        wd   = '0;
        half = '0;
        bpos = '0;
        done = 1'b0;
        if (bit_en) begin
            for (int c = 0; c < NCH; c++) begin
                done = 1'b0;
                tmp  = '0;
                if (cfg[c].en && (bit_idx == cfg[c].pos)) begin
                    tmp[WORD_W-1] = rx_sd;
                    st_d.acc[c]   = tmp;
                    st_d.cnt[c]   = CNT_W'(1);
                end else if (st_q.cnt[c] != '0) begin
                    tmp  = st_q.acc[c];
                    bpos = BIT_W'(WORD_W - 1 - int'(st_q.cnt[c]));
                    tmp[bpos]   = rx_sd;
                    st_d.acc[c] = tmp;
                    if (st_q.cnt[c] + CNT_W'(1) == ch_width(cfg[c])) begin
                        done        = 1'b1;
                        st_d.cnt[c] = '0;
                    end else begin
                        st_d.cnt[c] = st_q.cnt[c] + CNT_W'(1);
                    end
                end
                if (done) begin
                    half = tmp[WORD_W-1:HALF_W];
                    if (pack_mode && (c == 0) && cfg[1].en) begin
                        st_d.hold = half;
                    end else begin
                        if (!pack_mode)  wd = tmp;
                        else if (c == 0) wd = {{HALF_W{1'b0}}, half};
                        else             wd = {half, cfg[0].en ? st_q.hold : {HALF_W{1'b0}}};
                        if (rx_full) begin
                            st_d.err = 1'b1;
                        end else begin
                            st_d.push = 1'b1;
                            st_d.word = wd;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_word = st_q.word;
    assign rx_push = st_q.push;
    assign rx_err  = st_q.err;
endmodule

// File: rtl/slot_codec.sv
module slot_codec
    import slot_codec_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bit_en,
    input  logic [9:0]  bit_idx,
    input  logic        frame_start,
    input  logic        pack_mode,
    input  logic [31:0] tx_cfg,
    input  logic [31:0] rx_cfg,
    input  logic [31:0] tx_word,
    input  logic        tx_valid,
    output logic        tx_pop,
    output logic        tx_err,
    output logic        tx_sd,
    input  logic        rx_sd,
    output logic [31:0] rx_word,
    output logic        rx_push,
    input  logic        rx_full,
    output logic        rx_err
);
    typedef struct packed {
        logic [WORD_W-1:0] txc;
        logic [WORD_W-1:0] rxc;
        logic              pk;
    } cfg_t;

    cfg_t cfg_d, cfg_q, eff;

    always_comb begin
        eff = cfg_q;
        if (frame_start) begin
            eff.txc = tx_cfg;
            eff.rxc = rx_cfg;
            eff.pk  = pack_mode;
        end
        cfg_d = eff;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    ch_cfg_t [NCH-1:0] tx_ch;
    ch_cfg_t [NCH-1:0] rx_ch;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign tx_ch[g] = pick_ch(eff.txc, g);
        assign rx_ch[g] = pick_ch(eff.rxc, g);
    end

    slot_tx u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .bit_idx  (bit_idx),
        .pack_mode(eff.pk),
        .cfg      (tx_ch),
        .tx_word  (tx_word),
        .tx_valid (tx_valid),
        .tx_pop   (tx_pop),
        .tx_err   (tx_err),
        .tx_sd    (tx_sd)
    );

    slot_rx u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .bit_idx  (bit_idx),
        .pack_mode(eff.pk),
        .cfg      (rx_ch),
        .rx_sd    (rx_sd),
        .rx_full  (rx_full),
        .rx_word  (rx_word),
        .rx_push  (rx_push),
        .rx_err   (rx_err)
    );
endmodule

// File: rtl/slot_codec_chk.sv
module slot_codec_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic tx_valid,
    input logic tx_pop,
    input logic tx_err,
    input logic tx_sd,
    input logic rx_push,
    input logic rx_full,
    input logic rx_err
);
    // R4: a pop is only issued while the FIFO offers a word
    a_r4_pop_has_word: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> tx_valid);

    // R4: words are only requested on a strobed bit
    a_r4_pop_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pop || tx_err) |-> bit_en);

    // R6: underrun replaces the pop
    a_r6_err_excl_pop: assert property (@(posedge clk) disable iff (!rst_n)
        tx_err |-> !tx_pop);

    // R2: serial output holds between strobes
    a_r2_sd_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(tx_sd));

    // R7: a push only follows a strobed bit
    a_r7_push_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> $past(bit_en));

    // R9: no push while the receive FIFO reported full
    a_r9_push_not_full: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !$past(rx_full));

    // R9: overrun replaces the push
    a_r9_err_excl_push: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_push && rx_err));
endmodule

bind slot_codec slot_codec_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_en  (bit_en),
    .tx_valid(tx_valid),
    .tx_pop  (tx_pop),
    .tx_err  (tx_err),
    .tx_sd   (tx_sd),
    .rx_push (rx_push),
    .rx_full (rx_full),
    .rx_err  (rx_err)
);

// File: tb/tb_slot_codec.sv
module tb_slot_codec;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bit_en;
    logic [9:0]  bit_idx;
    logic        frame_start;
    logic        pack_mode;
    logic [31:0] tx_cfg;
    logic [31:0] rx_cfg;
    logic [31:0] tx_word;
    logic        tx_valid;
    logic        tx_pop;
    logic        tx_err;
    logic        tx_sd;
    logic        rx_sd;
    logic [31:0] rx_word;
    logic        rx_push;
    logic        rx_full;
    logic        rx_err;

    always #2 clk = ~clk;

    slot_codec dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_idx(bit_idx),
        .frame_start(frame_start), .pack_mode(pack_mode),
        .tx_cfg(tx_cfg), .rx_cfg(rx_cfg), .tx_word(tx_word),
        .tx_valid(tx_valid), .tx_pop(tx_pop), .tx_err(tx_err),
        .tx_sd(tx_sd), .rx_sd(rx_sd), .rx_word(rx_word),
        .rx_push(rx_push), .rx_full(rx_full), .rx_err(rx_err)
    );

    int total = 0;
    int fails = 0;

    logic [31:0] fifo [8];
    int wr = 0;
    int rd = 0;
    assign tx_valid = (rd < wr);
    assign tx_word  = fifo[rd % 8];

    logic [63:0] txcap;
    logic [63:0] rxv;
    int          pops, tx_errs, npush, rx_errs, stray;
    int          pop_at [4];
    logic [31:0] rxw [4];
    int          mid_idx = -1;
    logic [31:0] mid_txcfg;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] cc(bit en, int pos, int code, bit ext);
        return {ext, en, 10'(pos), 4'(code)};
    endfunction

    function automatic logic [63:0] put(logic [63:0] v, int pos, int w, logic [31:0] val);
        for (int k = 0; k < w; k++) v[pos + k] = val[31 - k];
        return v;
    endfunction

    task automatic fifo_reset();
        rd = 0;
        wr = 0;
    endtask

    task automatic fifo_add(logic [31:0] w);
        fifo[wr % 8] = w;
        wr++;
    endtask

    task automatic run_frame();
        logic p;
        txcap = '0; pops = 0; tx_errs = 0; npush = 0; rx_errs = 0; stray = 0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            bit_en = 1'b1;
            bit_idx = 10'(i);
            frame_start = (i == 0);
            rx_sd = rxv[i];
            if (i == mid_idx) tx_cfg = mid_txcfg;
            #1;
            p = tx_pop;
            if (p) begin
                if (pops < 4) pop_at[pops] = i;
                pops++;
            end
            if (tx_err) tx_errs++;
            @(posedge clk);
            #1;
            txcap[i] = tx_sd;
            if (p) rd++;
            if (rx_push) begin
                if (npush < 4) rxw[npush] = rx_word;
                npush++;
            end
            if (rx_err) rx_errs++;
            @(negedge clk);
            bit_en = 1'b0;
            frame_start = 1'b0;
            @(posedge clk);
            #1;
            if (rx_push || rx_err) stray++;
        end
    endtask

    task automatic t_reset();
        chk("R11 reset outputs", {59'd0, tx_sd, tx_pop, tx_err, rx_push, rx_err}, 64'd0);
    endtask

    task automatic t_unpacked();
        logic [63:0] e;
        fifo_reset();
        fifo_add(32'hA5C3_1234);
        fifo_add(32'h8F0F_F0AA);
        pack_mode = 1'b0;
        tx_cfg = {cc(1, 1, 8, 0), cc(1, 33, 0, 1)};
        rx_cfg = '0;
        rxv = '1;
        run_frame();
        e = put(put(64'd0, 1, 16, 32'hA5C3_1234), 33, 24, 32'h8F0F_F0AA);
        chk("R2 R3 unpacked tx frame", txcap, e);
        chk("R4 pop count", 64'(pops), 64'd2);
        chk("R4 first pop at window start", 64'(pop_at[0]), 64'd1);
        chk("R4 second pop at window start", 64'(pop_at[1]), 64'd33);
        chk("R12 rx disabled no push", 64'(npush + rx_errs + stray), 64'd0);
    endtask

    task automatic t_width();
        fifo_reset();
        fifo_add(32'hC0FF_EE81);
        tx_cfg = {cc(1, 0, 15, 1), cc(0, 40, 8, 0)};
        run_frame();
        chk("R1 width clamped to 32", txcap, put(64'd0, 0, 32, 32'hC0FF_EE81));
        chk("R3 disabled channel no pop", 64'(pops), 64'd1);
        fifo_reset();
        fifo_add(32'h9234_5677);
        tx_cfg = {cc(1, 0, 8, 1), 16'h0000};
        run_frame();
        chk("R1 width 32 via ext", txcap, put(64'd0, 0, 32, 32'h9234_5677));
    endtask

    task automatic t_packed();
        logic [63:0] e;
        fifo_reset();
        fifo_add(32'h1357_9BDF);
        pack_mode = 1'b1;
        tx_cfg = {cc(1, 1, 8, 0), cc(1, 33, 8, 0)};
        run_frame();
        e = put(put(64'd0, 1, 16, 32'h9BDF_0000), 33, 16, 32'h1357_0000);
        chk("R5 packed tx frame", txcap, e);
        chk("R5 one pop per packed word", 64'(pops), 64'd1);
        pack_mode = 1'b0;
    endtask

    task automatic t_underrun();
        fifo_reset();
        tx_cfg = {cc(1, 1, 8, 0), cc(1, 33, 0, 1)};
        run_frame();
        chk("R6 underrun sends zeros", txcap, 64'd0);
        chk("R6 underrun error pulses", 64'(tx_errs), 64'd2);
        chk("R6 no pop on underrun", 64'(pops), 64'd0);
    endtask

    task automatic t_rx_unpacked();
        fifo_reset();
        tx_cfg = '0;
        rx_cfg = {cc(1, 2, 0, 1), cc(1, 34, 8, 0)};
        rxv = put(put('1, 2, 24, 32'hABCD_EF00), 34, 16, 32'h5A5A_0000);
        run_frame();
        chk("R7 push count", 64'(npush), 64'd2);
        chk("R7 ch1 word left aligned", 64'(rxw[0]), 64'h0000_0000_ABCD_EF00);
        chk("R7 ch2 word left aligned", 64'(rxw[1]), 64'h0000_0000_5A5A_0000);
        chk("R12 tx disabled silent", txcap, 64'd0);
        chk("R12 tx disabled no pop", 64'(pops + tx_errs), 64'd0);
    endtask

    task automatic t_rx_packed();
        pack_mode = 1'b1;
        rx_cfg = {cc(1, 1, 8, 0), cc(1, 33, 4, 0)};
        rxv = put(put('1, 1, 16, 32'hC001_0000), 33, 12, 32'hABC0_0000);
        run_frame();
        chk("R8 packed rx one push", 64'(npush), 64'd1);
        chk("R8 R1 packed rx word", 64'(rxw[0]), 64'h0000_0000_ABC0_C001);
        pack_mode = 1'b0;
    endtask

    task automatic t_rx_full();
        rx_full = 1'b1;
        rx_cfg = {cc(1, 2, 8, 0), 16'h0000};
        rxv = '1;
        run_frame();
        chk("R9 full drops word", 64'(npush), 64'd0);
        chk("R9 overrun error", 64'(rx_errs), 64'd1);
        rx_full = 1'b0;
        rx_cfg = '0;
    endtask

    task automatic t_latch();
        fifo_reset();
        fifo_add(32'hB700_0000);
        fifo_add(32'hFFFF_FFFF);
        tx_cfg = {cc(1, 20, 0, 0), 16'h0000};
        mid_txcfg = '0;
        mid_idx = 5;
        run_frame();
        mid_idx = -1;
        chk("R10 mid-frame change ignored", txcap, put(64'd0, 20, 8, 32'hB700_0000));
        chk("R10 old config still pops", 64'(pops), 64'd1);
        run_frame();
        chk("R10 new config at next frame", txcap, 64'd0);
        chk("R10 new config no pop", 64'(pops), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        bit_en = 1'b0;
        bit_idx = '0;
        frame_start = 1'b0;
        pack_mode = 1'b0;
        tx_cfg = '0;
        rx_cfg = '0;
        rx_sd = 1'b0;
        rx_full = 1'b0;
        rxv = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unpacked();
        t_width();
        t_packed();
        t_underrun();
        t_rx_unpacked();
        t_rx_packed();
        t_rx_full();
        t_latch();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule